// File: doc/BRIEF.md
# Transceiver Driver Protection Controller

This block sits between the fault sensors of a bus transceiver and its output stage. It decides when the transmit driver may run, when the receiver is attached to the bus, and when the low-power wake comparator is powered. Its inputs are a supply-undervoltage flag, an overtemperature flag, the transmit data line and a standby request. The flags and the transmit line come from other clock domains or from analog circuits, so every input passes through a two-flop synchroniser before any logic uses it.

An overtemperature event opens a latched lockout. The lockout closes only when, in the same cycle, the synchronised overtemperature flag is low and the synchronised transmit line is high. Requiring the transmit line to be high stops the driver from switching on and off as the die temperature drifts around the trip point. Supply undervoltage overrides every other condition. It detaches the transceiver from the bus and powers down the wake comparator. The standby request is ignored while the supply is low. Once the supply recovers, the standby value last captured before the fault is applied for one cycle, and after that the live request is followed again.

Top module: `xcvr_guard`

## Requirements
- R1: While reset is asserted (rst_n low), the outputs are drv_en_o=0, bus_engage_o=0, wake_cmp_en_o=0 and stby_state_o=1, whatever the input levels.
- R2: Each input reaches the logic through two synchronising flops. A change driven between clock edges shows on the outputs only after the second rising edge that follows it.
- R3: While the synchronised overtemperature flag is high, drv_en_o is 0. The flag sets a lockout latch.
- R4: The lockout latch clears on the first edge at which the synchronised overtemperature flag is low and the synchronised transmit line is high. drv_en_o goes to 1 in the cycle after that edge, and not before.
- R5: A high transmit line does not release the lockout while the overtemperature flag is still high.
- R6: While the synchronised undervoltage flag is high, bus_engage_o and drv_en_o are 0, even when an overtemperature lockout is also present. An undervoltage event does not clear an overtemperature lockout.
- R7: wake_cmp_en_o is 0 only while the synchronised undervoltage flag is high. It stays 1 in standby and during overtemperature.
- R8: While undervoltage is present, changes on stby_req_i do not change stby_state_o.
- R9: When the supply recovers, stby_state_o keeps the value held from before the fault for one cycle. On the next edge it takes the current synchronised standby request.
- R10: When stby_state_o is 1, bus_engage_o and drv_en_o are 0.
- R11: When there is no fault and no standby, drv_en_o, bus_engage_o and wake_cmp_en_o are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_flag_i | input | 1 | Supply undervoltage flag, asynchronous, 1 = supply low |
| ot_flag_i | input | 1 | Overtemperature flag, asynchronous, 1 = die too hot |
| txd_i | input | 1 | Transmit data line, asynchronous, 1 = recessive |
| stby_req_i | input | 1 | Standby request, asynchronous, 1 = standby |
| drv_en_o | output | 1 | Output driver enable |
| bus_engage_o | output | 1 | Receiver attached to the bus |
| wake_cmp_en_o | output | 1 | Low-power wake comparator power enable |
| stby_state_o | output | 1 | Standby state in effect |

## Verification
The checker tests the gating on every cycle, with each output compared against the input levels from two or three edges earlier. It checks that undervoltage forces the bus, the driver and the wake comparator off, that overtemperature forces the driver off, that the driver never runs while the bus is detached, and that the standby state holds still while the supply is low. The lockout release cannot be checked that way. Its release needs both conditions together, it lands one edge after the synchronised inputs, and it must survive an undervoltage event, so only the bench scenarios can show it, at the exact cycle it happens. The same applies to the single cycle in which the held standby value is applied after recovery.

// File: rtl/xg_pkg.sv
// Package xg_pkg: types and constants shared by the protection controller.
// Assumes that every consumer takes the synchronised inputs as one packed struct.
package xg_pkg;

    // Bundle of synchronised inputs, most significant bit first
    typedef struct packed {
        logic uv;
        logic ot;
        logic txd;
        logic stby;
    } xg_in_t;

    localparam int unsigned XG_IN_W = $bits(xg_in_t);

    // Reset image of the synchroniser: supply bad, cool die, line recessive, standby
    localparam xg_in_t XG_IN_RST = '{uv: 1'b1, ot: 1'b0, txd: 1'b1, stby: 1'b1};

endpackage

// File: rtl/xg_sync.sv
// Module xg_sync: multi-bit chain of synchronising flops, one chain per bit.
// Assumes the bits are independent levels. No relation between bits is kept.
module xg_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift each input bit through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[LAST];

endmodule

// File: rtl/xg_thermal_lock.sv
// Module xg_thermal_lock: latched overtemperature lockout of the driver.
// Assumes synchronised inputs. The lock is set by the hot flag and cleared
// only when the die is cool and the transmit line is high in the same cycle.
module xg_thermal_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic txd_i,
    output logic hold_o
);

    logic lock_q;

    // Set on hot, keep until cool and recessive together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (hot_i) begin
            lock_q <= 1'b1;
        end else if (txd_i) begin
            lock_q <= 1'b0;
        end
    end

    // The live flag blocks at once, the latch covers the release wait
    assign hold_o = hot_i | lock_q;

endmodule

// File: rtl/xg_supply_gate.sv
// Module xg_supply_gate: supply-fault gating and standby capture.
// Assumes synchronised inputs. The standby value is captured only while the
// supply is good and is frozen while it is low.
module xg_supply_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_i,
    input  logic stby_i,
    output logic stby_o,
    output logic engage_o,
    output logic wake_o
);

    logic stby_q;

    // Capture the standby request only while the supply is good
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby_q <= 1'b1;
        end else if (!uv_i) begin
            stby_q <= stby_i;
        end
    end

    // Bus attached only with a good supply and not in standby
    always_comb begin
        stby_o   = stby_q;
        engage_o = !uv_i && !stby_q;
        wake_o   = !uv_i;
    end

endmodule

// File: rtl/xcvr_guard.sv
// Module xcvr_guard: top of the transceiver driver protection controller.
// Assumes asynchronous fault and data inputs. Undervoltage overrides everything,
// and the overtemperature lockout gates only the driver.
module xcvr_guard #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag_i,
    input  logic ot_flag_i,
    input  logic txd_i,
    input  logic stby_req_i,
    output logic drv_en_o,
    output logic bus_engage_o,
    output logic wake_cmp_en_o,
    output logic stby_state_o
);

    import xg_pkg::*;

    xg_in_t raw_in;
    xg_in_t syn_in;
    logic   ot_hold;
    logic   engage;

    // Gather the raw inputs into one bundle
    always_comb begin
        raw_in.uv   = uv_flag_i;
        raw_in.ot   = ot_flag_i;
        raw_in.txd  = txd_i;
        raw_in.stby = stby_req_i;
    end

    xg_sync #(
        .WIDTH   (XG_IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (XG_IN_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    xg_thermal_lock therm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_i  (syn_in.ot),
        .txd_i  (syn_in.txd),
        .hold_o (ot_hold)
    );

    xg_supply_gate supply_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .uv_i     (syn_in.uv),
        .stby_i   (syn_in.stby),
        .stby_o   (stby_state_o),
        .engage_o (engage),
        .wake_o   (wake_cmp_en_o)
    );

    // Driver runs only on an attached bus with no thermal hold
    always_comb begin
        bus_engage_o = engage;
        drv_en_o     = engage && !ot_hold;
    end

endmodule

// File: rtl/xcvr_guard_chk.sv
// Module xcvr_guard_chk: port-level checker bound to xcvr_guard.
// Assumes two synchroniser stages. Each output is related to the inputs from
// two or three edges back, and a small counter keeps the look-back inside the
// cycles since reset.
module xcvr_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic uv_flag_i,
    input logic ot_flag_i,
    input logic drv_en_o,
    input logic bus_engage_o,
    input logic wake_cmp_en_o,
    input logic stby_state_o
);

    logic [2:0] cyc_q;

    // Count edges since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
    end

    AST_UV_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd3 && $past(uv_flag_i, 2)) |-> (!bus_engage_o && !drv_en_o)); // R6

    AST_WAKE_ONLY_UV: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd3) |-> (wake_cmp_en_o == !$past(uv_flag_i, 2))); // R7

    AST_HOT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd3 && $past(ot_flag_i, 2)) |-> !drv_en_o); // R3

    AST_DRIVE_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_o || stby_state_o) |-> (bus_engage_o == !stby_state_o)); // R10

    AST_STBY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd4 && $past(uv_flag_i, 3)) |-> $stable(stby_state_o)); // R8

endmodule

bind xcvr_guard xcvr_guard_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .uv_flag_i     (uv_flag_i),
    .ot_flag_i     (ot_flag_i),
    .drv_en_o      (drv_en_o),
    .bus_engage_o  (bus_engage_o),
    .wake_cmp_en_o (wake_cmp_en_o),
    .stby_state_o  (stby_state_o)
);

// File: tb/xcvr_guard_tb_top.sv
// Bench xcvr_guard_tb_top: scoreboard bench for the protection controller.
// The driver tasks set the inputs and queue the expected outputs. The monitor
// compares them one time step after each falling edge.
module xcvr_guard_tb_top;

    typedef struct {
        logic  drv;
        logic  eng;
        logic  wake;
        logic  stby;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv = 1'b0;
    logic ot = 1'b0;
    logic txd = 1'b1;
    logic stby = 1'b0;
    logic drv_en, bus_engage, wake_en, stby_state;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    xcvr_guard dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .uv_flag_i     (uv),
        .ot_flag_i     (ot),
        .txd_i         (txd),
        .stby_req_i    (stby),
        .drv_en_o      (drv_en),
        .bus_engage_o  (bus_engage),
        .wake_cmp_en_o (wake_en),
        .stby_state_o  (stby_state)
    );

    // Set all four inputs at once
    task automatic put(input logic u, input logic o, input logic t, input logic s);
        uv = u; ot = o; txd = t; stby = s;
    endtask

    // Wait n falling edges, then queue one expected output set
    task automatic expect_in(input int n, input logic d, input logic e,
                             input logic w, input logic s, input string tag);
        exp_t it;
        repeat (n) @(negedge clk);
        it.drv = d; it.eng = e; it.wake = w; it.stby = s; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: pop expected items and compare them with the outputs
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_checks++;
            if ({drv_en, bus_engage, wake_en, stby_state} !==
                {it.drv, it.eng, it.wake, it.stby}) begin
                n_fails++;
                $display("FAIL %s: drv/eng/wake/stby actual %b%b%b%b expected %b%b%b%b",
                         it.tag, drv_en, bus_engage, wake_en, stby_state,
                         it.drv, it.eng, it.wake, it.stby);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Stimulus scenarios
    initial begin
        put(0, 0, 1, 0);
        expect_in(3, 0, 0, 0, 1, "R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        expect_in(4, 1, 1, 1, 0, "R11 normal operation");

        put(1, 0, 1, 0);
        expect_in(1, 1, 1, 1, 0, "R2 first stage only");
        expect_in(1, 0, 0, 0, 0, "R2 R6 undervoltage after two edges");

        put(1, 0, 1, 1);
        expect_in(4, 0, 0, 0, 0, "R8 standby ignored in undervoltage");

        put(0, 0, 1, 1);
        expect_in(2, 1, 1, 1, 0, "R9 held standby applied");
        expect_in(1, 0, 0, 1, 1, "R9 R10 live standby then");
        expect_in(2, 0, 0, 1, 1, "R7 R10 wake on in standby");

        put(0, 0, 1, 0);
        expect_in(4, 1, 1, 1, 0, "R11 back to normal");

        put(0, 1, 0, 0);
        expect_in(2, 0, 1, 1, 0, "R3 R7 hot disables driver");
        put(0, 1, 1, 0);
        expect_in(4, 0, 1, 1, 0, "R5 txd high while hot");
        put(0, 0, 0, 0);
        expect_in(4, 0, 1, 1, 0, "R4 cool but txd low");
        put(0, 0, 1, 0);
        expect_in(2, 0, 1, 1, 0, "R4 release not yet");
        expect_in(1, 1, 1, 1, 0, "R4 release");

        put(1, 1, 0, 0);
        expect_in(4, 0, 0, 0, 0, "R6 undervoltage over hot");
        put(1, 0, 0, 0);
        expect_in(4, 0, 0, 0, 0, "R6 undervoltage alone");
        put(0, 0, 0, 0);
        expect_in(4, 0, 1, 1, 0, "R6 R4 lock survives undervoltage");
        put(0, 0, 1, 0);
        expect_in(4, 1, 1, 1, 0, "R4 final release");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule